// File: doc/BRIEF.md
# Ethernet Statistics Counter Bank

This block keeps the transmit and receive statistics for one Ethernet MAC in a bank of 32 counters. The MAC datapaths report events as single-cycle pulses. Frame-completion pulses carry a length. Dedicated pins report collisions, late collisions and excessive-collision aborts. A generic pulse vector adds one to any counter. Every event that arrives while the port is in Ethernet mode is folded into the counters on the same clock edge.

Software reaches the bank through a plain register port. It selects a counter by number, writes a preset value, or reads a counter as a 64-bit word one cycle later. When a counter rolls over, a sticky overflow flag rises and the number of the counter that wrapped is captured. A write-one-to-clear pulse clears both.

Events are pulses and there is no back-pressure. The bank accepts every pulse in the cycle it arrives, and no pulse is ever held or dropped. For that reason the event and register pins carry no ready signal.

Top module: `stat_counter_bank`

## Requirements
- R1: After reset every counter reads zero, `ovf_flag` is 0 and `ovf_idx` is 0.
- R2: Counters 0 (transmit bytes) and 8 (receive bytes) are 64 bits wide. All other counters are 32 bits wide. A write to a 32-bit counter keeps only `sw_wdata[31:0]`, and a read of one returns zero in bits 63:32.
- R3: A write of zero clears the selected counter. A write of any other value loads that value, and later events count on from it.
- R4: `sw_rvalid` is high exactly in the cycle after `sw_rd_en`. `sw_rdata` then holds the selected counter as it was before that clock edge.
- R5: A `tx_done` pulse with `tx_err` low adds `tx_len` to counter 0 and 1 to counter 4. With `tx_err` high, neither counter changes.
- R6: Counter 1 adds 1 for each `tx_coll` and 1 for each `tx_late_coll`, and adds 16 for each `tx_excess_abort`. Counter 2 adds 1 for each `tx_late_coll`. Counter 3 adds 1 for each `tx_excess_abort`. Pulses in the same cycle are summed.
- R7: An `rx_done` pulse with `rx_err` low adds `rx_len` to counter 8 and 1 to counter 9. With `rx_err` high, it adds 1 to counter 10 and leaves counter 8 unchanged.
- R8: Bit i of `gen_evt` adds 1 to counter i. This adds on top of any dedicated event in the same cycle.
- R9: A counter that passes its maximum wraps modulo its width and keeps counting. `ovf_flag` is then set and stays set, and `ovf_idx` takes the counter's number. A later wrap overwrites `ovf_idx`. When several counters wrap in one cycle, the lowest number is stored.
- R10: An `ovf_clr` pulse clears `ovf_flag` and sets `ovf_idx` to 0. If a wrap happens in the same cycle, the wrap wins.
- R11: While `eth_mode` is low, no event changes any counter. Software writes still apply.
- R12: A write to a counter in the same cycle as an event on that counter loads the written value exactly. A write never sets `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eth_mode | input | 1 | Counting enable (Ethernet mode) |
| tx_done | input | 1 | Transmit frame finished pulse |
| tx_len | input | LEN_W | Frame length, destination address to CRC |
| tx_err | input | 1 | Frame had collision, underrun or control error |
| tx_coll | input | 1 | Collision pulse |
| tx_late_coll | input | 1 | Late collision pulse |
| tx_excess_abort | input | 1 | Frame aborted after 16 consecutive collisions |
| rx_done | input | 1 | Receive frame finished pulse |
| rx_len | input | LEN_W | Received frame length |
| rx_err | input | 1 | Received frame had an error |
| gen_evt | input | NUM_CTR | Per-counter increment-by-one pulses |
| sw_wr_en | input | 1 | Software write strobe |
| sw_rd_en | input | 1 | Software read strobe |
| sw_idx | input | IDX_W | Counter number for read or write |
| sw_wdata | input | 64 | Write value |
| sw_rvalid | output | 1 | Read data valid |
| sw_rdata | output | 64 | Read data, zero-extended |
| ovf_clr | input | 1 | Write-one-to-clear of overflow status |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_idx | output | IDX_W | Number of the last counter that wrapped |

## Verification
The bound assertions check four things on every cycle:
- the read strobe-to-valid timing;
- that no counter moves while counting is disabled and no write is pending;
- that a write lands exactly as masked;
- that the overflow flag rises after any wrap and falls only on a clear.

Some behaviour only the bench's scenarios and its cycle model can show:
- the arithmetic of each event rule, such as the +16 on an abort and the summing of coincident pulses;
- the priority among simultaneous wraps;
- the width truncation of 32-bit presets;
- the carry across the 64-bit byte counters.

// File: rtl/stat_bank_pkg.sv
package stat_bank_pkg;
  localparam int unsigned WIDE_W      = 64;
  localparam int unsigned NARROW_W    = 32;
  localparam int unsigned EXCESS_STEP = 16;

  // counter numbers with dedicated update rules
  localparam int unsigned C_TX_BYTES  = 0;
  localparam int unsigned C_TX_COLL   = 1;
  localparam int unsigned C_TX_LATE   = 2;
  localparam int unsigned C_TX_EXCESS = 3;
  localparam int unsigned C_TX_FRAMES = 4;
  localparam int unsigned C_RX_BYTES  = 8;
  localparam int unsigned C_RX_FRAMES = 9;
  localparam int unsigned C_RX_ERRS   = 10;

  function automatic bit is_wide(int unsigned n);
    return (n == C_TX_BYTES) || (n == C_RX_BYTES);
  endfunction
endpackage

// File: rtl/stat_evt_decode.sv
module stat_evt_decode
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CTR = 32,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned INC_W  = LEN_W + 1
) (
  input  logic                            eth_mode,
  input  logic                            tx_done,
  input  logic [LEN_W-1:0]                tx_len,
  input  logic                            tx_err,
  input  logic                            tx_coll,
  input  logic                            tx_late_coll,
  input  logic                            tx_excess_abort,
  input  logic                            rx_done,
  input  logic [LEN_W-1:0]                rx_len,
  input  logic                            rx_err,
  input  logic [NUM_CTR-1:0]              gen_evt,
  output logic [NUM_CTR-1:0][INC_W-1:0]   inc
);
  always_comb begin
    for (int i = 0; i < NUM_CTR; i++) inc[i] = INC_W'(gen_evt[i]);
    if (tx_done && !tx_err) begin
      inc[C_TX_BYTES]  = inc[C_TX_BYTES] + INC_W'(tx_len);
      inc[C_TX_FRAMES] = inc[C_TX_FRAMES] + INC_W'(1);
    end
    inc[C_TX_COLL] = inc[C_TX_COLL] + INC_W'(tx_coll) + INC_W'(tx_late_coll);
    if (tx_excess_abort) begin
      inc[C_TX_COLL]   = inc[C_TX_COLL] + INC_W'(EXCESS_STEP);
      inc[C_TX_EXCESS] = inc[C_TX_EXCESS] + INC_W'(1);
    end
    inc[C_TX_LATE] = inc[C_TX_LATE] + INC_W'(tx_late_coll);
    if (rx_done) begin
      if (rx_err) begin
        inc[C_RX_ERRS] = inc[C_RX_ERRS] + INC_W'(1);
      end else begin
        inc[C_RX_BYTES]  = inc[C_RX_BYTES] + INC_W'(rx_len);
        inc[C_RX_FRAMES] = inc[C_RX_FRAMES] + INC_W'(1);
      end
    end
    if (!eth_mode) inc = '0;
  end
endmodule

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
  parameter int unsigned W     = 32,
  parameter int unsigned INC_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] inc,
  input  logic             wr_en,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     value,
  output logic             wrap
);
  logic [W:0] sum;

  assign sum  = {1'b0, value} + (W+1)'(inc);
  assign wrap = !wr_en && sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n)     value <= '0;
    else if (wr_en) value <= wdata;
    else            value <= sum[W-1:0];
  end
endmodule

// File: rtl/stat_ovf_track.sv
module stat_ovf_track #(
  parameter int unsigned NUM_CTR = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_CTR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CTR-1:0] wrap_vec,
  input  logic               clr,
  output logic               flag,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] first_idx;
  logic             any_wrap;

  always_comb begin
    first_idx = '0;
    for (int i = NUM_CTR - 1; i >= 0; i--)
      if (wrap_vec[i]) first_idx = IDX_W'(i);
  end
  assign any_wrap = |wrap_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      idx  <= '0;
    end else if (any_wrap) begin
      flag <= 1'b1;
      idx  <= first_idx;
    end else if (clr) begin
      flag <= 1'b0;
      idx  <= '0;
    end
  end
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CTR = 32,
  parameter int unsigned LEN_W   = 16,
  localparam int unsigned IDX_W  = $clog2(NUM_CTR),
  localparam int unsigned INC_W  = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eth_mode,
  input  logic               tx_done,
  input  logic [LEN_W-1:0]   tx_len,
  input  logic               tx_err,
  input  logic               tx_coll,
  input  logic               tx_late_coll,
  input  logic               tx_excess_abort,
  input  logic               rx_done,
  input  logic [LEN_W-1:0]   rx_len,
  input  logic               rx_err,
  input  logic [NUM_CTR-1:0] gen_evt,
  input  logic               sw_wr_en,
  input  logic               sw_rd_en,
  input  logic [IDX_W-1:0]   sw_idx,
  input  logic [63:0]        sw_wdata,
  output logic               sw_rvalid,
  output logic [63:0]        sw_rdata,
  input  logic               ovf_clr,
  output logic               ovf_flag,
  output logic [IDX_W-1:0]   ovf_idx
);
  logic [NUM_CTR-1:0][INC_W-1:0]  inc;
  logic [NUM_CTR-1:0][WIDE_W-1:0] cnt_q;
  logic [NUM_CTR-1:0]             wrap_vec;

  stat_evt_decode #(.NUM_CTR(NUM_CTR), .LEN_W(LEN_W)) u_decode (
    .eth_mode(eth_mode), .tx_done(tx_done), .tx_len(tx_len), .tx_err(tx_err),
    .tx_coll(tx_coll), .tx_late_coll(tx_late_coll),
    .tx_excess_abort(tx_excess_abort), .rx_done(rx_done), .rx_len(rx_len),
    .rx_err(rx_err), .gen_evt(gen_evt), .inc(inc)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    logic sel_wr;
    assign sel_wr = sw_wr_en && (sw_idx == IDX_W'(g));
    if (is_wide(g)) begin : g_wide
      logic [WIDE_W-1:0] v;
      stat_ctr_cell #(.W(WIDE_W), .INC_W(INC_W)) u_cell (
        .clk(clk), .rst_n(rst_n), .inc(inc[g]), .wr_en(sel_wr),
        .wdata(sw_wdata), .value(v), .wrap(wrap_vec[g])
      );
      assign cnt_q[g] = v;
    end else begin : g_narrow
      logic [NARROW_W-1:0] v;
      stat_ctr_cell #(.W(NARROW_W), .INC_W(INC_W)) u_cell (
        .clk(clk), .rst_n(rst_n), .inc(inc[g]), .wr_en(sel_wr),
        .wdata(sw_wdata[NARROW_W-1:0]), .value(v), .wrap(wrap_vec[g])
      );
      assign cnt_q[g] = {{(WIDE_W-NARROW_W){1'b0}}, v};
    end
  end

  stat_ovf_track #(.NUM_CTR(NUM_CTR)) u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap_vec(wrap_vec), .clr(ovf_clr),
    .flag(ovf_flag), .idx(ovf_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_rvalid <= 1'b0;
      sw_rdata  <= '0;
    end else begin
      sw_rvalid <= sw_rd_en;
      if (sw_rd_en) sw_rdata <= cnt_q[sw_idx];
    end
  end
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
  import stat_bank_pkg::*;
#(
  parameter int unsigned NUM_CTR = 32,
  parameter int unsigned IDX_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     eth_mode,
  input logic                     sw_wr_en,
  input logic                     sw_rd_en,
  input logic [IDX_W-1:0]         sw_idx,
  input logic [63:0]              sw_wdata,
  input logic                     sw_rvalid,
  input logic                     ovf_clr,
  input logic                     ovf_flag,
  input logic [IDX_W-1:0]         ovf_idx,
  input logic [NUM_CTR-1:0][63:0] cnt_q,
  input logic [NUM_CTR-1:0]       wrap_vec
);
  logic [63:0] wr_exp;
  assign wr_exp = is_wide(int'(sw_idx)) ? sw_wdata : {32'h0, sw_wdata[31:0]};

  AST_RD_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rd_en |=> sw_rvalid); // R4
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_rd_en |=> !sw_rvalid); // R4
  AST_IDLE_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!eth_mode && !sw_wr_en) |=> $stable(cnt_q)); // R11
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> cnt_q[$past(sw_idx)] == $past(wr_exp)); // R12
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap_vec) |=> ovf_flag); // R9
  AST_FLAG_FALLS_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag) |-> $past(ovf_clr)); // R10
  AST_IDX_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_clr && !(|wrap_vec)) |=> $stable(ovf_idx) && $stable(ovf_flag)); // R9
endmodule

bind stat_counter_bank stat_bank_chk #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .eth_mode(eth_mode), .sw_wr_en(sw_wr_en),
  .sw_rd_en(sw_rd_en), .sw_idx(sw_idx), .sw_wdata(sw_wdata),
  .sw_rvalid(sw_rvalid), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
  .ovf_idx(ovf_idx), .cnt_q(cnt_q), .wrap_vec(wrap_vec)
);

// File: tb/test_stat_counter_bank.sv
`timescale 1ns/1ps
module test_stat_counter_bank;
  localparam int N = 32;
  localparam int LW = 16;

  logic clk = 1'b0, rst_n = 1'b0, eth_mode = 1'b1;
  logic tx_done = 0, tx_err = 0, tx_coll = 0, tx_late_coll = 0, tx_excess_abort = 0;
  logic rx_done = 0, rx_err = 0;
  logic [LW-1:0] tx_len = '0, rx_len = '0;
  logic [N-1:0] gen_evt = '0;
  logic sw_wr_en = 0, sw_rd_en = 0, ovf_clr = 0;
  logic [4:0] sw_idx = '0;
  logic [63:0] sw_wdata = '0;
  logic sw_rvalid, ovf_flag;
  logic [63:0] sw_rdata;
  logic [4:0] ovf_idx;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  stat_counter_bank i_stat_counter_bank (
    .clk(clk), .rst_n(rst_n), .eth_mode(eth_mode), .tx_done(tx_done), .tx_len(tx_len),
    .tx_err(tx_err), .tx_coll(tx_coll), .tx_late_coll(tx_late_coll),
    .tx_excess_abort(tx_excess_abort), .rx_done(rx_done), .rx_len(rx_len),
    .rx_err(rx_err), .gen_evt(gen_evt), .sw_wr_en(sw_wr_en), .sw_rd_en(sw_rd_en),
    .sw_idx(sw_idx), .sw_wdata(sw_wdata), .sw_rvalid(sw_rvalid), .sw_rdata(sw_rdata),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag), .ovf_idx(ovf_idx)
  );

  task automatic chk(string tag, longint unsigned got, longint unsigned exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  longint unsigned m_cnt[N];
  bit m_flag, m_rv;
  int m_idx;
  longint unsigned m_rd;

  function automatic bit wide(int n);
    return n == 0 || n == 8;
  endfunction

  task automatic model_step();
    longint unsigned add[N];
    int first;
    if (!rst_n) begin
      foreach (m_cnt[i]) m_cnt[i] = 0;
      m_flag = 0; m_idx = 0; m_rv = 0; m_rd = 0;
      return;
    end
    m_rv = sw_rd_en;
    if (sw_rd_en) m_rd = m_cnt[sw_idx];
    foreach (add[i]) add[i] = gen_evt[i];
    if (tx_done && !tx_err) begin add[0] += tx_len; add[4] += 1; end
    add[1] += tx_coll + tx_late_coll + (tx_excess_abort ? 16 : 0);
    add[2] += tx_late_coll;
    add[3] += tx_excess_abort;
    if (rx_done) begin
      if (rx_err) add[10] += 1;
      else begin add[8] += rx_len; add[9] += 1; end
    end
    if (!eth_mode) foreach (add[i]) add[i] = 0;
    first = -1;
    for (int i = 0; i < N; i++) begin
      if (sw_wr_en && sw_idx == i) begin
        m_cnt[i] = wide(i) ? sw_wdata : (sw_wdata & 64'hFFFF_FFFF);
      end else if (add[i] != 0) begin
        longint unsigned nv = m_cnt[i] + add[i];
        bit w;
        if (wide(i)) w = nv < m_cnt[i];
        else begin
          w = nv >= 64'h1_0000_0000;
          if (w) nv -= 64'h1_0000_0000;
        end
        m_cnt[i] = nv;
        if (w && first < 0) first = i;
      end
    end
    if (first >= 0) begin m_flag = 1; m_idx = first; end
    else if (ovf_clr) begin m_flag = 0; m_idx = 0; end
  endtask

  always @(posedge clk) begin
    model_step();
    #1;
    if (rst_n && !done) begin
      chk("R4", sw_rvalid, m_rv, "model rvalid");
      if (m_rv) chk("R4", sw_rdata, m_rd, "model rdata");
      chk("R9", ovf_flag, m_flag, "model ovf_flag");
      chk("R9", ovf_idx, m_idx, "model ovf_idx");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic clear_in();
    tx_done = 0; tx_err = 0; tx_coll = 0; tx_late_coll = 0; tx_excess_abort = 0;
    rx_done = 0; rx_err = 0; gen_evt = '0; sw_wr_en = 0; sw_rd_en = 0; ovf_clr = 0;
  endtask

  task automatic step();
    @(negedge clk); clear_in();
  endtask

  task automatic wr(int n, logic [63:0] v);
    @(negedge clk); sw_wr_en = 1; sw_idx = 5'(n); sw_wdata = v;
    step();
  endtask

  task automatic rd_chk(int n, longint unsigned exp, string tag);
    @(negedge clk); sw_rd_en = 1; sw_idx = 5'(n);
    step();
    chk(tag, sw_rdata, exp, $sformatf("counter %0d", n));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", ovf_flag, 0, "flag after reset");
    chk("R1", ovf_idx, 0, "idx after reset");
    rd_chk(0, 0, "R1"); rd_chk(8, 0, "R1"); rd_chk(31, 0, "R1");

    // R5 transmit frames
    @(negedge clk); tx_done = 1; tx_len = 64; step();
    rd_chk(0, 64, "R5"); rd_chk(4, 1, "R5");
    @(negedge clk); tx_done = 1; tx_len = 100; tx_err = 1; step();
    rd_chk(0, 64, "R5"); rd_chk(4, 1, "R5");

    // R6 collisions
    @(negedge clk); tx_coll = 1; step();
    @(negedge clk); tx_late_coll = 1; step();
    @(negedge clk); tx_excess_abort = 1; step();
    rd_chk(1, 18, "R6"); rd_chk(2, 1, "R6"); rd_chk(3, 1, "R6");
    @(negedge clk); tx_coll = 1; tx_late_coll = 1; tx_excess_abort = 1; step();
    rd_chk(1, 36, "R6"); rd_chk(2, 2, "R6"); rd_chk(3, 2, "R6");

    // R7 receive frames
    @(negedge clk); rx_done = 1; rx_len = 1518; step();
    @(negedge clk); rx_done = 1; rx_len = 77; rx_err = 1; step();
    rd_chk(8, 1518, "R7"); rd_chk(9, 1, "R7"); rd_chk(10, 1, "R7");

    // R8 generic pulses, summed with dedicated events
    repeat (3) begin @(negedge clk); gen_evt[20] = 1; step(); end
    rd_chk(20, 3, "R8");
    @(negedge clk); gen_evt[0] = 1; tx_done = 1; tx_len = 10; step();
    rd_chk(0, 75, "R8");

    // R11 mode gating
    @(negedge clk); eth_mode = 0; tx_done = 1; tx_len = 50; gen_evt = '1; tx_coll = 1; step();
    rd_chk(0, 75, "R11"); rd_chk(20, 3, "R11"); rd_chk(1, 36, "R11");
    wr(20, 7);
    rd_chk(20, 7, "R11");
    @(negedge clk); eth_mode = 1;

    // R3 preset and clear
    wr(20, 0);
    rd_chk(20, 0, "R3");
    wr(20, 100);
    @(negedge clk); gen_evt[20] = 1; step();
    rd_chk(20, 101, "R3");

    // R2 widths
    wr(2, 64'h1234_5678_9ABC_DEF0);
    rd_chk(2, 64'h9ABC_DEF0, "R2");
    wr(8, 64'hFFFF_FFFF_0000_0001);
    rd_chk(8, 64'hFFFF_FFFF_0000_0001, "R2");

    // R12 write wins, write never flags overflow
    @(negedge clk); sw_wr_en = 1; sw_idx = 3; sw_wdata = 500; tx_excess_abort = 1; step();
    rd_chk(3, 500, "R12"); rd_chk(1, 52, "R12");
    @(negedge clk); sw_wr_en = 1; sw_idx = 1; sw_wdata = 64'hFFFF_FFFF; tx_coll = 1; step();
    rd_chk(1, 64'hFFFF_FFFF, "R12");
    chk("R12", ovf_flag, 0, "flag after write");

    // R9 wrap, sticky flag, continue counting
    @(negedge clk); tx_coll = 1; step();
    chk("R9", ovf_flag, 1, "flag after wrap");
    chk("R9", ovf_idx, 1, "idx after wrap");
    rd_chk(1, 0, "R9");
    @(negedge clk); tx_coll = 1; step();
    rd_chk(1, 1, "R9");
    chk("R9", ovf_flag, 1, "flag sticky");

    // R9 64-bit wrap overwrites index
    wr(0, 64'hFFFF_FFFF_FFFF_FFF0);
    @(negedge clk); tx_done = 1; tx_len = 16'h20; step();
    rd_chk(0, 64'h10, "R9");
    chk("R9", ovf_idx, 0, "idx after 64-bit wrap");

    // R10 clear
    @(negedge clk); ovf_clr = 1; step();
    chk("R10", ovf_flag, 0, "flag after clear");

    // R9 lowest number wins on simultaneous wraps
    wr(7, 64'hFFFF_FFFF);
    wr(5, 64'hFFFF_FFFF);
    @(negedge clk); gen_evt[5] = 1; gen_evt[7] = 1; step();
    chk("R9", ovf_idx, 5, "priority idx");
    rd_chk(5, 0, "R9"); rd_chk(7, 0, "R9");

    // R10 wrap beats clear in the same cycle
    wr(6, 64'hFFFF_FFFF);
    @(negedge clk); ovf_clr = 1; gen_evt[6] = 1; step();
    chk("R10", ovf_flag, 1, "flag wrap vs clear");
    chk("R10", ovf_idx, 6, "idx wrap vs clear");

    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule